// File: doc/BRIEF.md
# Priority-First Weighted Token Arbiter

This block shares one bus among several DMA channel requesters. Every requester has a request line, a grant line and a burst-complete line. It also has two programmable settings: a priority level and a weight. The first stage of arbitration compares priority. Among the requesters that can currently be served, the highest priority level wins. Ties at that level are broken round-robin, starting from the channel after the last one granted.

When the global weighted mode is on, a channel can be served only while it holds at least one token. Each granted burst costs its channel one token. Tokens are reloaded from the weights in three cases: when weighted mode is switched on, when a programmable bus-cycle timer expires, and when every requesting channel has run dry. Over one reload window, the channels therefore share bursts in proportion to their weights. A channel with weight zero is never served in this mode. When weighted mode is off, the block is a plain priority arbiter with round-robin tie breaking, and weights and tokens play no part.

A grant is registered and stays on its channel until that channel pulses its burst-complete line. There is no preemption. A one-cycle write port sets the priorities, the weights, the mode bit and the timer reload value.

Top module: `wtok_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, grant is all zero. Every weight starts at 1, every priority at 0, and weighted mode is off. With these defaults and weighted mode switched on, two requesters alternate.
- R2: Grant is one-hot or zero, changes only on a clock edge, and a new grant goes only to a channel whose request was high at the deciding edge.
- R3: A grant stays unchanged until the granted channel's done bit is sampled high. The grant then drops at that edge, and a new grant can appear at the following edge. With done delayed until the fifth cycle of a burst, grant stays high for exactly 5 cycles.
- R4: Among the candidates, a higher priority value always wins over a lower one. In weighted mode the candidates are the requesters that hold tokens, so a channel that has used up its tokens gives way to a lower-priority channel.
- R5: Candidates of equal top priority are served round-robin in ascending index order, starting from the channel after the last grant. After reset, the search starts at channel 0.
- R6: In weighted mode each grant consumes one token of the granted channel, and a channel with no tokens is not granted. With weights 1 and 15 and both channels requesting, the grant order is channel 0 once and then channel 1 fifteen times, and this pattern repeats.
- R7: In weighted mode a channel whose weight is 0 is never granted, while other channels continue to be served.
- R8: When no grant is active, some channel requests, and no requesting channel holds a token, all tokens are reloaded from the weights in that cycle. No grant is issued in a reload cycle.
- R9: In weighted mode a timer counts clock cycles down from its reload value. On expiry it reloads every channel's tokens and restarts. A reload value of 0 is ignored, so the previous value is kept.
- R10: With weighted mode off, weights and tokens are ignored. A weight-0 channel is still served. Switching the mode on reloads all tokens and restarts the timer.
- R11: Configuration is written when cfg_we is high at a clock edge. cfg_kind 0 sets the priority of channel cfg_chan from cfg_wdata[2:0], and values above 5 are stored as 5. Kind 1 sets the weight from cfg_wdata[3:0]. Kind 2 sets the mode from cfg_wdata[0]. Kind 3 sets the timer reload from cfg_wdata[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Field selector: 0 priority, 1 weight, 2 mode, 3 timer reload |
| cfg_chan | input | CH_W | Channel addressed by priority and weight writes |
| cfg_wdata | input | TMO_W | Write data |
| req | input | N_CH | Per-channel request |
| done | input | N_CH | Per-channel burst complete |
| grant | output | N_CH | Registered one-hot grant |

## Verification
A token counter that is off by one moves the burst mix at once. In the 1-to-15 pattern, channel 0 then shows up a second time, or channel 1 fewer than fifteen times, within the first sixteen grants. Wrong priority or pointer state shows up as an out-of-order grant at the very next arbitration, and the scoreboard catches that on the first mismatched burst. A timer that never expires, or that accepts a zero reload, starves the weight-1 channel: within about 130 cycles it gets four bursts instead of six or more. A broken hold or release shows up as a grant that is too short or too long for the delayed-done burst.

// File: rtl/wta_pkg.sv
package wta_pkg;
  typedef enum logic [1:0] {
    CFG_PRIO = 2'd0,
    CFG_WGT  = 2'd1,
    CFG_MODE = 2'd2,
    CFG_TMO  = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/wta_cfg_regs.sv
module wta_cfg_regs #(
  parameter int N_CH     = 4,
  parameter int CH_W     = 2,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 5,
  parameter int WGT_W    = 4,
  parameter int TMO_W    = 16,
  parameter int DEF_TMO  = 2000
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  wta_pkg::cfg_kind_e               cfg_kind,
  input  logic [CH_W-1:0]                  cfg_chan,
  input  logic [TMO_W-1:0]                 cfg_wdata,
  output logic [N_CH-1:0][PRIO_W-1:0]      prio,
  output logic [N_CH-1:0][WGT_W-1:0]       wgt,
  output logic                             wmode,
  output logic                             mode_rise,
  output logic [TMO_W-1:0]                 tmo_val,
  output logic                             tmo_wr
);
  import wta_pkg::*;

  logic                 wmode_d;
  logic [PRIO_W-1:0]    prio_in;
  logic [PRIO_W-1:0]    prio_sat;

  // clamp priority writes to the top legal level
  assign prio_in  = cfg_wdata[PRIO_W-1:0];
  assign prio_sat = (prio_in > PRIO_W'(MAX_PRIO)) ? PRIO_W'(MAX_PRIO) : prio_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      wmode   <= 1'b0;
      wmode_d <= 1'b0;
      tmo_val <= TMO_W'(DEF_TMO);
      tmo_wr  <= 1'b0;
    end else begin
      wmode_d <= wmode;
      tmo_wr  <= 1'b0;
      if (cfg_we) begin
        case (cfg_kind)
          CFG_MODE: wmode <= cfg_wdata[0];
          CFG_TMO: begin
            if (cfg_wdata != '0) begin
              tmo_val <= cfg_wdata;
              tmo_wr  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_rise = wmode & ~wmode_d;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        prio[c] <= '0;
        wgt[c]  <= WGT_W'(1);
      end else if (cfg_we && cfg_chan == CH_W'(c)) begin
        if (cfg_kind == CFG_PRIO) prio[c] <= prio_sat;
        if (cfg_kind == CFG_WGT)  wgt[c]  <= cfg_wdata[WGT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wta_refill_timer.sv
module wta_refill_timer #(
  parameter int TMO_W   = 16,
  parameter int DEF_TMO = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [TMO_W-1:0] reload,
  output logic             expire,
  output logic [TMO_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= TMO_W'(DEF_TMO);
    else if (restart || !run)    cnt <= reload;
    else if (cnt == TMO_W'(1))   cnt <= reload;
    else                         cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == TMO_W'(1));
endmodule

// File: rtl/wta_token_bank.sv
module wta_token_bank #(
  parameter int N_CH  = 4,
  parameter int CH_W  = 2,
  parameter int WGT_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       refill,
  input  logic                       consume,
  input  logic [CH_W-1:0]            cons_ch,
  input  logic [N_CH-1:0][WGT_W-1:0] wgt,
  output logic [N_CH-1:0]            has_tok
);
  for (genvar c = 0; c < N_CH; c++) begin : g_tok
    logic [WGT_W-1:0] tok;
    always_ff @(posedge clk) begin
      if (rst)
        tok <= WGT_W'(1);
      else if (refill)
        tok <= wgt[c];
      else if (consume && cons_ch == CH_W'(c) && tok != '0)
        tok <= tok - 1'b1;
    end
    assign has_tok[c] = (tok != '0);
  end
endmodule

// File: rtl/wta_pick.sv
module wta_pick #(
  parameter int N_CH   = 4,
  parameter int CH_W   = 2,
  parameter int PRIO_W = 3
) (
  input  logic [N_CH-1:0]             cand,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio,
  input  logic [CH_W-1:0]             last,
  output logic                        valid,
  output logic [CH_W-1:0]             idx
);
  logic [PRIO_W-1:0] best;
  logic              found;
  int                j;

  always_comb begin
    best = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (cand[c] && prio[c] > best) best = prio[c];
    end
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = 1; k <= N_CH; k++) begin
      j = int'(last) + k;
      if (j >= N_CH) j = j - N_CH;
      if (!found && cand[CH_W'(j)] && prio[CH_W'(j)] == best) begin
        idx   = CH_W'(j);
        found = 1'b1;
      end
    end
    valid = found;
  end
endmodule

// File: rtl/wtok_arbiter.sv
module wtok_arbiter #(
  parameter int N_CH     = 4,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 5,
  parameter int WGT_W    = 4,
  parameter int TMO_W    = 16,
  parameter int DEF_TMO  = 2000,
  localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [TMO_W-1:0] cfg_wdata,
  input  logic [N_CH-1:0]  req,
  input  logic [N_CH-1:0]  done,
  output logic [N_CH-1:0]  grant
);
  import wta_pkg::*;

  logic [N_CH-1:0][PRIO_W-1:0] prio;
  logic [N_CH-1:0][WGT_W-1:0]  wgt;
  logic                        wmode, mode_rise, tmo_wr, expire;
  logic [TMO_W-1:0]            tmo_val, tmo_cnt;
  logic [N_CH-1:0]             has_tok, cand;
  logic                        busy, pick_valid, take, exhaust, refill;
  logic [CH_W-1:0]             owner, last, pick_idx;

  wta_cfg_regs #(
    .N_CH(N_CH), .CH_W(CH_W), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO),
    .WGT_W(WGT_W), .TMO_W(TMO_W), .DEF_TMO(DEF_TMO)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind_e'(cfg_kind)),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .prio(prio), .wgt(wgt),
    .wmode(wmode), .mode_rise(mode_rise), .tmo_val(tmo_val), .tmo_wr(tmo_wr)
  );

  // all requesters dry while the bus is free
  assign exhaust = wmode && !busy && (req != '0) && ((req & has_tok) == '0);
  assign refill  = mode_rise | expire | exhaust;

  wta_refill_timer #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_tmr (
    .clk(clk), .rst(rst), .run(wmode),
    .restart(mode_rise | exhaust | tmo_wr),
    .reload(tmo_val), .expire(expire), .cnt(tmo_cnt)
  );

  assign cand = wmode ? (req & has_tok) : req;

  wta_pick #(.N_CH(N_CH), .CH_W(CH_W), .PRIO_W(PRIO_W)) u_pick (
    .cand(cand), .prio(prio), .last(last), .valid(pick_valid), .idx(pick_idx)
  );

  assign take = !busy && !refill && pick_valid;

  wta_token_bank #(.N_CH(N_CH), .CH_W(CH_W), .WGT_W(WGT_W)) u_tok (
    .clk(clk), .rst(rst), .refill(refill), .consume(take && wmode),
    .cons_ch(pick_idx), .wgt(wgt), .has_tok(has_tok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= '0;
      last  <= CH_W'(N_CH - 1);
      grant <= '0;
    end else if (busy) begin
      if (done[owner]) begin
        busy  <= 1'b0;
        grant <= '0;
      end
    end else if (take) begin
      busy  <= 1'b1;
      owner <= pick_idx;
      last  <= pick_idx;
      grant <= N_CH'(1) << pick_idx;
    end
  end
endmodule

// File: rtl/wta_checker.sv
module wta_checker #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] req,
  input logic [N_CH-1:0] done,
  input logic [N_CH-1:0] grant,
  input logic [N_CH-1:0] has_tok,
  input logic            wmode
);
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_grant_to_req_r2: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && $past(grant) == '0) |-> (($past(req) & grant) != '0));

  p_hold_until_done_r3: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & done) == '0) |=> (grant == $past(grant)));

  p_release_on_done_r3: assert property (@(posedge clk) disable iff (rst)
    ((grant & done) != '0) |=> (grant == '0));

  p_token_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && $past(grant) == '0 && $past(wmode)) |-> (($past(has_tok) & grant) != '0));
endmodule

bind wtok_arbiter wta_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .req(req), .done(done), .grant(grant),
  .has_tok(has_tok), .wmode(wmode)
);

// File: tb/tb_wtok_arbiter.sv
`timescale 1ns/1ps
module tb_wtok_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [1:0]  cfg_chan = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  req = '0;
  logic [3:0]  done = '0;
  logic [3:0]  grant;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  string cur_tag = "R5";
  int gcount[4];
  int hold = 0;
  int hcnt = 0;
  int last_len = 0;
  logic [3:0] prev_g = '0;

  always #2.5 clk = ~clk;

  wtok_arbiter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .req(req), .done(done),
    .grant(grant)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int oh2idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  // requester model and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      prev_g = '0;
      hcnt   = 0;
      done   = '0;
    end else begin
      if (grant != '0) begin
        done = (hcnt >= hold) ? grant : 4'b0;
        hcnt++;
        if (prev_g == '0) begin
          int gi;
          gi = oh2idx(grant);
          if (gi >= 0) gcount[gi]++;
          if (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check(gi == e, cur_tag, gi, e);
          end
        end
      end else begin
        if (prev_g != '0) last_len = hcnt;
        hcnt = 0;
        done = '0;
      end
      prev_g = grant;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = '0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input int kind, input int ch, input int val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_kind  = kind[1:0];
    cfg_chan  = ch[1:0];
    cfg_wdata = val[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) gcount[i] = 0;
  endtask

  task automatic push(input int ch);
    exp_q.push_back(ch);
  endtask

  task automatic wait_q();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() != 0) begin
      check(1'b0, cur_tag, exp_q.size(), 0);
      exp_q.delete();
    end
  endtask

  task automatic stop_req();
    req = '0;
    repeat (10) @(negedge clk);
    check(grant == '0, "R2", grant, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    // R1: reset state and defaults
    do_reset();
    @(negedge clk);
    check(grant == '0, "R1", grant, 0);
    cur_tag = "R1";
    cfg(2, 0, 1);
    push(0); push(1); push(0); push(1);
    req = 4'b0011;
    wait_q();
    stop_req();

    // R6, R8: weights 1 and 15
    do_reset();
    cur_tag = "R6,R8";
    cfg(1, 0, 1);
    cfg(1, 1, 15);
    cfg(2, 0, 1);
    clear_counts();
    for (int r = 0; r < 2; r++) begin
      push(0);
      for (int i = 0; i < 15; i++) push(1);
    end
    req = 4'b0011;
    wait_q();
    check(gcount[0] == 2, "R6", gcount[0], 2);
    check(gcount[1] == 30, "R6", gcount[1], 30);
    stop_req();

    // R4: priority among token holders
    do_reset();
    cur_tag = "R4";
    cfg(0, 2, 5);
    cfg(1, 2, 2);
    cfg(1, 0, 3);
    cfg(2, 0, 1);
    for (int r = 0; r < 2; r++) begin
      push(2); push(2); push(0); push(0); push(0);
    end
    req = 4'b0101;
    wait_q();
    stop_req();

    // R5, R10: round robin, weights ignored when mode is off
    do_reset();
    cur_tag = "R5,R10";
    cfg(1, 0, 0);
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 4; i++) push(i);
    req = 4'b1111;
    wait_q();
    stop_req();

    // R11: priority saturation, R4 higher level wins
    do_reset();
    cur_tag = "R11";
    cfg(0, 0, 5);
    cfg(0, 3, 7);
    cfg(0, 1, 3);
    cfg(0, 2, 3);
    push(0); push(3); push(0); push(3);
    req = 4'b1111;
    wait_q();
    stop_req();

    // R7: weight zero never served
    do_reset();
    cfg(1, 3, 0);
    cfg(2, 0, 1);
    clear_counts();
    req = 4'b1000;
    repeat (40) @(negedge clk);
    check(gcount[3] == 0, "R7", gcount[3], 0);
    req = 4'b1001;
    repeat (20) @(negedge clk);
    check(gcount[0] > 0, "R7", gcount[0], 1);
    check(gcount[3] == 0, "R7", gcount[3], 0);
    stop_req();

    // R3: hold until done
    do_reset();
    hold = 4;
    req = 4'b0010;
    repeat (20) @(negedge clk);
    check(last_len == 5, "R3", last_len, 5);
    stop_req();
    hold = 0;

    // R9: timer refill lets the weight-1 channel in more often
    do_reset();
    cfg(1, 0, 1);
    cfg(1, 1, 15);
    cfg(3, 0, 20);
    cfg(2, 0, 1);
    clear_counts();
    req = 4'b0011;
    repeat (130) @(negedge clk);
    check(gcount[0] >= 6, "R9", gcount[0], 6);
    stop_req();

    // R9: zero reload is ignored
    do_reset();
    cfg(1, 0, 1);
    cfg(1, 1, 15);
    cfg(3, 0, 20);
    cfg(3, 0, 0);
    cfg(2, 0, 1);
    clear_counts();
    req = 4'b0011;
    repeat (130) @(negedge clk);
    check(gcount[0] >= 6, "R9", gcount[0], 6);
    stop_req();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule